// File: doc/BRIEF.md
# Floating-Point Compare and Sign Unit

This block evaluates one of six relational tests between two floating-point operands, or produces a sign-modified copy of the first operand. It has no memory of earlier operations. Each accepted request produces its answer on the registered result one clock later. The exponent and mantissa field widths are parameters. The default build is half precision, with 5 exponent bits and 10 mantissa bits. The same RTL serves single precision with 8 and 23.

A relational test returns a single truth bit in the least significant position of the result word. Values whose exponent field is zero are treated as zero, so subnormal encodings and both signed zeros count as the same value. Infinities and NaNs get no special treatment. Their encodings are ordered like any other finite pattern.

The absolute-value and negate operations touch only the sign bit of operand A.

Top module: `fp_cmpsgn`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. `result` is updated only on cycles where `in_valid` is 1, and it holds its value otherwise.
- R3: The opcode encoding is 0 equal, 1 not-equal, 2 greater-than, 3 greater-or-equal, 4 less-than, 5 less-or-equal, 6 absolute value, 7 negate. For opcodes 0 to 5, result bit 0 carries the truth of "A op B" and every other result bit is 0.
- R4: Equal is true when A and B denote the same value and not-equal is its complement; +0 and -0 compare equal.
- R5: Any operand whose exponent field (the bits just below the sign) is zero is taken as the value zero, whatever its mantissa and sign bits.
- R6: Ordering follows sign-magnitude rules: any negative nonzero value is below zero and below any positive value, and between positives the larger magnitude (exponent, then mantissa) is the larger value.
- R7: When both operands are negative, the one with the larger magnitude is the smaller value.
- R8: Absolute value returns A with the sign bit (the top bit) cleared and all other bits unchanged, including for zero-exponent inputs.
- R9: Negate returns A with the sign bit inverted and all other bits unchanged.
- R10: For absolute value and negate, operand B has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| op_a | input | 1+EXP_W+MAN_W | First operand: sign, exponent, mantissa from MSB down |
| op_b | input | 1+EXP_W+MAN_W | Second operand, same layout |
| opcode | input | 3 | Operation select, encoding in R3 |
| out_valid | output | 1 | Result word holds a new answer |
| result | output | 1+EXP_W+MAN_W | Comparison bit in LSB, or the sign-modified operand |

## Verification
On every cycle, the assertions check the one-cycle valid pipeline and the hold of the result between requests. They also check that comparison results have zero upper bits, that absolute value and negate change only the sign bit, that two zero-exponent operands always compare equal, and that a positive nonzero value is greater than a negative one. Full numeric ordering cannot be captured by one cycle-local property. This covers negative pairs, differing exponents and mantissa tie-breaks. The bench shows it by sweeping every operand pair and every opcode of a small format against a signed integer model of each encoding's value.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [2:0] {
        OP_EQ  = 3'd0,
        OP_NE  = 3'd1,
        OP_GT  = 3'd2,
        OP_GE  = 3'd3,
        OP_LT  = 3'd4,
        OP_LE  = 3'd5,
        OP_ABS = 3'd6,
        OP_NEG = 3'd7
    } fcs_op_e;

    // Decoded control: which relations make the test true, and sign action.
    typedef struct packed {
        logic is_cmp;
        logic take_eq;
        logic take_lt;
        logic take_gt;
        logic sign_clr;
        logic sign_inv;
    } fcs_ctrl_t;

    // Relation of A to B; exactly one bit set.
    typedef struct packed {
        logic eq;
        logic lt;
        logic gt;
    } fcs_rel_t;

    function automatic fcs_ctrl_t fcs_decode(fcs_op_e op);
        fcs_ctrl_t c;
        c = '0;
        c.is_cmp = 1'b1;
        case (op)
            OP_EQ:   c.take_eq = 1'b1;
            OP_NE:   begin c.take_lt = 1'b1; c.take_gt = 1'b1; end
            OP_GT:   c.take_gt = 1'b1;
            OP_GE:   begin c.take_gt = 1'b1; c.take_eq = 1'b1; end
            OP_LT:   c.take_lt = 1'b1;
            OP_LE:   begin c.take_lt = 1'b1; c.take_eq = 1'b1; end
            OP_ABS:  begin c.is_cmp = 1'b0; c.sign_clr = 1'b1; end
            default: begin c.is_cmp = 1'b0; c.sign_inv = 1'b1; end
        endcase
        return c;
    endfunction

    function automatic logic fcs_select(fcs_ctrl_t c, fcs_rel_t r);
        return (c.take_eq & r.eq) | (c.take_lt & r.lt) | (c.take_gt & r.gt);
    endfunction

endpackage

// File: rtl/fcs_opdec.sv
module fcs_opdec
    import fcs_pkg::*;
(
    input  logic [2:0] opcode,
    output fcs_ctrl_t  ctrl
);
    always_comb begin
        ctrl = fcs_decode(fcs_op_e'(opcode));
    end
endmodule

// File: rtl/fcs_order.sv
module fcs_order
    import fcs_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    output fcs_rel_t             rel
);
    localparam int W     = 1 + EXP_W + MAN_W;
    localparam int MAG_W = EXP_W + MAN_W;

    logic             a_zero, b_zero;
    logic             a_neg, b_neg;
    logic [MAG_W-1:0] a_mag, b_mag;
    logic             mag_eq, mag_lt;

    always_comb begin
        a_zero = (a[W-2:MAN_W] == '0);
        b_zero = (b[W-2:MAN_W] == '0);
        // Zero-exponent values collapse to an unsigned zero.
        a_neg  = a[W-1] & ~a_zero;
        b_neg  = b[W-1] & ~b_zero;
        a_mag  = a_zero ? '0 : a[MAG_W-1:0];
        b_mag  = b_zero ? '0 : b[MAG_W-1:0];
        mag_eq = (a_mag == b_mag);
        mag_lt = (a_mag <  b_mag);

        rel = '0;
        if (a_neg != b_neg) begin
            rel.lt = a_neg;
            rel.gt = b_neg;
        end else if (mag_eq) begin
            rel.eq = 1'b1;
        end else if (a_neg) begin
            rel.lt = ~mag_lt;
            rel.gt = mag_lt;
        end else begin
            rel.lt = mag_lt;
            rel.gt = ~mag_lt;
        end
    end
endmodule

// File: rtl/fcs_signop.sv
module fcs_signop
    import fcs_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  fcs_ctrl_t            ctrl,
    output logic [EXP_W+MAN_W:0] y
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic new_sign;

    always_comb begin
        new_sign = (a[W-1] & ~ctrl.sign_clr) ^ ctrl.sign_inv;
        y        = {new_sign, a[W-2:0]};
    end
endmodule

// File: rtl/fp_cmpsgn.sv
module fp_cmpsgn
    import fcs_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [EXP_W+MAN_W:0]  op_a,
    input  logic [EXP_W+MAN_W:0]  op_b,
    input  logic [2:0]            opcode,
    output logic                  out_valid,
    output logic [EXP_W+MAN_W:0]  result
);
    localparam int W = 1 + EXP_W + MAN_W;

    fcs_ctrl_t    ctrl;
    fcs_rel_t     rel;
    logic [W-1:0] sign_word;
    logic [W-1:0] next_word;

    fcs_opdec u_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    fcs_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ord (
        .a   (op_a),
        .b   (op_b),
        .rel (rel)
    );

    fcs_signop #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sgn (
        .a    (op_a),
        .ctrl (ctrl),
        .y    (sign_word)
    );

    always_comb begin
        if (ctrl.is_cmp) begin
            next_word    = '0;
            next_word[0] = fcs_select(ctrl, rel);
        end else begin
            next_word = sign_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_word;
            end
        end
    end
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [EXP_W+MAN_W:0] op_a,
    input logic [EXP_W+MAN_W:0] op_b,
    input logic [2:0]           opcode,
    input logic                 out_valid,
    input logic [EXP_W+MAN_W:0] result
);
    localparam int W = 1 + EXP_W + MAN_W;

    p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_result_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    p_cmp_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode <= 3'd5) |=> (result[W-1:1] == '0));

    p_zero_equal_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 3'd0 && op_a[W-2:MAN_W] == '0 && op_b[W-2:MAN_W] == '0)
        |=> result[0]);

    p_pos_above_neg_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 3'd2 && !op_a[W-1] && op_a[W-2:MAN_W] != '0
         && op_b[W-1] && op_b[W-2:MAN_W] != '0) |=> result[0]);

    p_abs_sign_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 3'd6) |=> (result == {1'b0, $past(op_a[W-2:0])}));

    p_neg_sign_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 3'd7)
        |=> (result[W-2:0] == $past(op_a[W-2:0]) && result[W-1] != $past(op_a[W-1])));

endmodule

bind fp_cmpsgn fcs_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fcs_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .opcode    (opcode),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/fp_cmpsgn_tb.sv
module fp_cmpsgn_tb_top;
    localparam int EW = 2;
    localparam int MW = 1;
    localparam int W  = 1 + EW + MW;
    localparam int N  = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [2:0]   opcode = '0;
    logic         out_valid;
    logic [W-1:0] result;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    fp_cmpsgn #(.EXP_W(EW), .MAN_W(MW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .opcode    (opcode),
        .out_valid (out_valid),
        .result    (result)
    );

    // Signed integer value of an encoding: 0 when the exponent field is 0.
    function automatic longint fval(logic [W-1:0] x);
        longint mag;
        int e;
        e = int'(x[W-2:MW]);
        if (e == 0) return 0;
        mag = ((longint'(1) << MW) + longint'(x[MW-1:0])) << e;
        return x[W-1] ? -mag : mag;
    endfunction

    function automatic logic [W-1:0] model(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
        longint va, vb;
        logic t;
        va = fval(a);
        vb = fval(b);
        case (op)
            3'd0: t = (va == vb);
            3'd1: t = (va != vb);
            3'd2: t = (va >  vb);
            3'd3: t = (va >= vb);
            3'd4: t = (va <  vb);
            3'd5: t = (va <= vb);
            3'd6: return {1'b0, a[W-2:0]};
            default: return {~a[W-1], a[W-2:0]};
        endcase
        return {{(W-1){1'b0}}, t};
    endfunction

    function automatic string tag(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
        if (op == 3'd6) return (b != 0) ? "R8/R10" : "R8";
        if (op == 3'd7) return (b != 0) ? "R9/R10" : "R9";
        if (a[W-2:MW] == 0 || b[W-2:MW] == 0) return "R3/R5";
        if (op <= 3'd1) return "R3/R4";
        if (a[W-1] && b[W-1]) return "R3/R7";
        return "R3/R6";
    endfunction

    task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp,
                         logic gv, logic ev);
        vectors++;
        if (got !== exp || gv !== ev) begin
            errors++;
            $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
                     req, got, gv, exp, ev);
        end
    endtask

    initial begin
        logic [W-1:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", result, '0, out_valid, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", result, '0, out_valid, 1'b0);

        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < N; a++) begin
                for (int b = 0; b < N; b++) begin
                    in_valid = 1'b1;
                    opcode   = 3'(op);
                    op_a     = W'(a);
                    op_b     = W'(b);
                    @(negedge clk);
                    check(tag(3'(op), W'(a), W'(b)), result,
                          model(3'(op), W'(a), W'(b)), out_valid, 1'b1);
                    if (b == N - 1) begin
                        // R2: idle cycle with changed inputs must not disturb result
                        held     = result;
                        in_valid = 1'b0;
                        op_a     = ~op_a;
                        op_b     = ~op_b;
                        opcode   = ~opcode;
                        @(negedge clk);
                        check("R2", result, held, out_valid, 1'b0);
                    end
                end
            end
        end

        // R4 spot check: +0 versus -0 under not-equal must be false
        in_valid = 1'b1;
        opcode   = 3'd1;
        op_a     = {1'b1, {(W-1){1'b0}}};
        op_b     = '0;
        @(negedge clk);
        check("R4", result, '0, out_valid, 1'b1);
        in_valid = 1'b0;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule